// File: doc/BRIEF.md
# Console I/O and Boot Lockout Register File

This block is the register file behind the console's decoded I/O window. A bus master reads a fixed identity word describing region, refresh rate, expansion presence and hardware revision. Through the same window it reaches two controller ports and one extension port. Each of these ports has a data register, which passes through to an external device, and a control register, which is held locally.

The block also drives a sound coprocessor. The master can request the coprocessor's bus and watch an inverted grant status, and it can release the coprocessor from reset. A boot lockout is made of two signature registers and a cartridge ROM enable bit. Each video enable flag is set only by a write of its exact 16-bit signature. Any other write to that register clears the flag.

Registers are selected with address bit 0 ignored. Reads are registered: `rdata` and the port read pulse both appear one cycle after the read strobe. Write side effects also take effect one cycle after the write strobe.

Top module: `iolock_regfile`

## Requirements
- R1: On reset, `rom_en`, both bits of `vid_en`, `bus_req`, `cop_run`, all port control registers, all port strobes and `rdata` are 0.
- R2: A read of 0xA10000 returns bit 7 = `strap_export`, bit 6 = `strap_50hz`, bit 5 = `strap_no_exp`, bit 4 = 0, bits 3:0 = `hw_ver`, and bits 15:8 = 0.
- R3: A read of a port data register returns that port's 8-bit `port_din` byte in bits 7:0, with bits 15:8 = 0. The registers are port 0 at 0xA10002, port 1 at 0xA10004 and the extension port (index 2) at 0xA10006. The read also raises a one-cycle pulse on that port's bit of `port_rd` only, in the cycle after the strobe. Port i uses bits [8i+7:8i] of `port_din` and `port_ctl`.
- R4: A write to a port data register pulses that port's bit of `port_wr` for one cycle and presents wdata[7:0] on `port_wdat`.
- R5: The control registers at 0xA10008, 0xA1000A and 0xA1000C (ports 0, 1 and 2) store wdata[7:0] on write. Reading one returns the stored byte zero-extended. A write also pulses `port_ctl_wr`.
- R6: A write to 0xA11100 loads `bus_req` from wdata[0]. A read of it returns 1 while `cop_grant` is 0 and 0 while it is 1, in bit 0 with the other bits 0.
- R7: A write to 0xA11200 loads `cop_run` from wdata[0].
- R8: A write to 0xA14000 sets `vid_en[0]` if wdata equals 0x5345 and clears it otherwise. A write to 0xA14002 sets `vid_en[1]` if wdata equals 0x4741 and clears it otherwise.
- R9: A write to 0xA14100 loads `rom_en` from wdata[0]. No other access changes `rom_en`.
- R10: Address bit 0 plays no part in register selection.
- R11: A read of any address not listed above, including the write-only registers, returns 0x0000. A write to an unlisted address changes no state.
- R12: When the read and write strobes are both high for the same register, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 24 | Byte address of the access |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| strap_export | input | 1 | 1 = export region, 0 = domestic |
| strap_50hz | input | 1 | 1 = 50 Hz video, 0 = 60 Hz |
| strap_no_exp | input | 1 | 1 = no expansion unit present |
| hw_ver | input | 4 | Hardware revision value |
| cop_grant | input | 1 | Coprocessor has granted its bus |
| port_din | input | 24 | Data bytes from the three port devices |
| rdata | output | 16 | Registered read data |
| port_rd | output | 3 | One-cycle data read pulse per port |
| port_wr | output | 3 | One-cycle data write pulse per port |
| port_ctl_wr | output | 3 | One-cycle control write pulse per port |
| port_wdat | output | 8 | Byte of the last port data write |
| port_ctl | output | 24 | Control register contents per port |
| bus_req | output | 1 | Coprocessor bus request |
| cop_run | output | 1 | Coprocessor reset release |
| vid_en | output | 2 | Video unlock flags |
| rom_en | output | 1 | Cartridge ROM enable |

## Verification
A read and a write can target the same register in one cycle. This matters most for a port control register, where the registered read path and the register update race on the same edge. The bench raises both strobes on a control register with a new value. It expects `rdata` to show the old byte after that edge and the new byte on the next read. It does the same on the bus request register, where the read must reflect only `cop_grant` and never the request being written.

// File: rtl/iolock_pkg.sv
package iolock_pkg;
    localparam int AW    = 24;
    localparam int DW    = 16;
    localparam int PW    = 8;
    localparam int NPORT = 3;
    localparam int VW    = 4;

    localparam logic [AW-1:0] A_VER     = 24'hA10000;
    localparam logic [AW-1:0] A_DAT0    = 24'hA10002;
    localparam logic [AW-1:0] A_CTL0    = 24'hA10008;
    localparam logic [AW-1:0] A_BUSREQ  = 24'hA11100;
    localparam logic [AW-1:0] A_COPRUN  = 24'hA11200;
    localparam logic [AW-1:0] A_SIG0    = 24'hA14000;
    localparam logic [AW-1:0] A_SIG1    = 24'hA14002;
    localparam logic [AW-1:0] A_ROMEN   = 24'hA14100;

    localparam logic [DW-1:0] SIG0_WORD = 16'h5345;
    localparam logic [DW-1:0] SIG1_WORD = 16'h4741;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_VER,
        SEL_DAT0, SEL_DAT1, SEL_DAT2,
        SEL_CTL0, SEL_CTL1, SEL_CTL2,
        SEL_BUSREQ, SEL_COPRUN, SEL_SIG0, SEL_SIG1, SEL_ROMEN
    } sel_e;

    typedef struct packed {
        logic          wr;
        logic          rd;
        sel_e          sel;
        logic [DW-1:0] wd;
    } acc_t;

    function automatic sel_e decode_addr(input logic [AW-1:0] even);
        sel_e s;
        s = SEL_NONE;
        for (int i = 0; i < NPORT; i++) begin
            if (even == A_DAT0 + AW'(2 * i)) s = sel_e'(int'(SEL_DAT0) + i);
            if (even == A_CTL0 + AW'(2 * i)) s = sel_e'(int'(SEL_CTL0) + i);
        end
        case (even)
            A_VER:    s = SEL_VER;
            A_BUSREQ: s = SEL_BUSREQ;
            A_COPRUN: s = SEL_COPRUN;
            A_SIG0:   s = SEL_SIG0;
            A_SIG1:   s = SEL_SIG1;
            A_ROMEN:  s = SEL_ROMEN;
            default:  ;
        endcase
        return s;
    endfunction

    function automatic sel_e dat_sel(input int idx);
        return sel_e'(int'(SEL_DAT0) + idx);
    endfunction

    function automatic sel_e ctl_sel(input int idx);
        return sel_e'(int'(SEL_CTL0) + idx);
    endfunction
endpackage

// File: rtl/iolock_decode.sv
module iolock_decode
    import iolock_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr_en,
    input  logic          rd_en,
    output acc_t          acc
);
    logic [AW-1:0] even_addr;

    // R10: the low address bit is masked before any comparison
    assign even_addr = addr & ~AW'(1);

    always_comb begin
        acc.wr  = wr_en;
        acc.rd  = rd_en;
        acc.sel = decode_addr(even_addr);
        acc.wd  = wdata;
    end
endmodule

// File: rtl/iolock_port_bank.sv
module iolock_port_bank
    import iolock_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  acc_t               acc,
    input  logic [NPORT*PW-1:0] port_din,
    output logic [NPORT-1:0]   port_rd,
    output logic [NPORT-1:0]   port_wr,
    output logic [NPORT-1:0]   port_ctl_wr,
    output logic [PW-1:0]      port_wdat,
    output logic [NPORT*PW-1:0] port_ctl,
    output logic               hit,
    output logic [DW-1:0]      rd_val
);
    logic [NPORT-1:0] dat_hit;
    logic [NPORT-1:0] ctl_hit;

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        assign dat_hit[i] = (acc.sel == dat_sel(i));
        assign ctl_hit[i] = (acc.sel == ctl_sel(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                port_rd[i]              <= 1'b0;
                port_wr[i]              <= 1'b0;
                port_ctl_wr[i]          <= 1'b0;
                port_ctl[i*PW +: PW]    <= '0;
            end else begin
                port_rd[i]     <= acc.rd && dat_hit[i];
                port_wr[i]     <= acc.wr && dat_hit[i];
                port_ctl_wr[i] <= acc.wr && ctl_hit[i];
                if (acc.wr && ctl_hit[i])
                    port_ctl[i*PW +: PW] <= acc.wd[PW-1:0];
            end
        end

        // R5
        ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(acc.wr && ctl_hit[i]))
                |-> (port_ctl[i*PW +: PW] == $past(acc.wd[PW-1:0])));

        // R3
        rd_pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
            port_rd[i] |-> $past(acc.rd && dat_hit[i]));
    end

    always_ff @(posedge clk) begin
        if (rst)
            port_wdat <= '0;
        else if (acc.wr && (|dat_hit))
            port_wdat <= acc.wd[PW-1:0];
    end

    always_comb begin
        hit    = (|dat_hit) || (|ctl_hit);
        rd_val = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (dat_hit[i]) rd_val = {{(DW-PW){1'b0}}, port_din[i*PW +: PW]};
            if (ctl_hit[i]) rd_val = {{(DW-PW){1'b0}}, port_ctl[i*PW +: PW]};
        end
    end

    // R3
    rd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(port_rd));
endmodule

// File: rtl/iolock_ctrl_regs.sv
module iolock_ctrl_regs
    import iolock_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  acc_t       acc,
    output logic       bus_req,
    output logic       cop_run,
    output logic [1:0] vid_en,
    output logic       rom_en
);
    logic wr_bus, wr_cop, wr_sig0, wr_sig1, wr_rom;

    always_comb begin
        wr_bus  = acc.wr && (acc.sel == SEL_BUSREQ);
        wr_cop  = acc.wr && (acc.sel == SEL_COPRUN);
        wr_sig0 = acc.wr && (acc.sel == SEL_SIG0);
        wr_sig1 = acc.wr && (acc.sel == SEL_SIG1);
        wr_rom  = acc.wr && (acc.sel == SEL_ROMEN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_req <= 1'b0;
            cop_run <= 1'b0;
            vid_en  <= 2'b00;
            rom_en  <= 1'b0;
        end else begin
            if (wr_bus)  bus_req   <= acc.wd[0];
            if (wr_cop)  cop_run   <= acc.wd[0];
            if (wr_sig0) vid_en[0] <= (acc.wd == SIG0_WORD);
            if (wr_sig1) vid_en[1] <= (acc.wd == SIG1_WORD);
            if (wr_rom)  rom_en    <= acc.wd[0];
        end
    end

    // R9
    rom_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc.wr && acc.sel == SEL_ROMEN) |=> $stable(rom_en));

    // R8
    vid0_sig_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vid_en[0]) |-> ($past(acc.wd) == SIG0_WORD && $past(acc.sel) == SEL_SIG0));

    // R8
    vid1_sig_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vid_en[1]) |-> ($past(acc.wd) == SIG1_WORD && $past(acc.sel) == SEL_SIG1));

    // R7
    cop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc.wr && acc.sel == SEL_COPRUN) |=> $stable(cop_run));

    // R6
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc.wr && acc.sel == SEL_BUSREQ) |=> $stable(bus_req));
endmodule

// File: rtl/iolock_regfile.sv
module iolock_regfile
    import iolock_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic                strap_export,
    input  logic                strap_50hz,
    input  logic                strap_no_exp,
    input  logic [VW-1:0]       hw_ver,
    input  logic                cop_grant,
    input  logic [NPORT*PW-1:0] port_din,
    output logic [DW-1:0]       rdata,
    output logic [NPORT-1:0]    port_rd,
    output logic [NPORT-1:0]    port_wr,
    output logic [NPORT-1:0]    port_ctl_wr,
    output logic [PW-1:0]       port_wdat,
    output logic [NPORT*PW-1:0] port_ctl,
    output logic                bus_req,
    output logic                cop_run,
    output logic [1:0]          vid_en,
    output logic                rom_en
);
    localparam int VER_PAD = DW - VW - 4;

    acc_t          acc;
    logic          bank_hit;
    logic [DW-1:0] bank_val;
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] ver_word;

    iolock_decode u_dec (
        .addr  (addr),
        .wdata (wdata),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .acc   (acc)
    );

    iolock_port_bank u_ports (
        .clk         (clk),
        .rst         (rst),
        .acc         (acc),
        .port_din    (port_din),
        .port_rd     (port_rd),
        .port_wr     (port_wr),
        .port_ctl_wr (port_ctl_wr),
        .port_wdat   (port_wdat),
        .port_ctl    (port_ctl),
        .hit         (bank_hit),
        .rd_val      (bank_val)
    );

    iolock_ctrl_regs u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .bus_req (bus_req),
        .cop_run (cop_run),
        .vid_en  (vid_en),
        .rom_en  (rom_en)
    );

    assign ver_word = {{VER_PAD{1'b0}}, strap_export, strap_50hz, strap_no_exp, 1'b0, hw_ver};

    always_comb begin
        rd_mux = '0;
        if (bank_hit)
            rd_mux = bank_val;
        else if (acc.sel == SEL_VER)
            rd_mux = ver_word;
        else if (acc.sel == SEL_BUSREQ)
            rd_mux = {{(DW-1){1'b0}}, ~cop_grant};
    end

    // R12: the read is captured from pre-edge state
    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (acc.rd)
            rdata <= rd_mux;
    end

    // R2
    ver_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(acc.rd && acc.sel == SEL_VER))
            |-> (rdata[7:5] == {$past(strap_export), $past(strap_50hz), $past(strap_no_exp)}
                 && rdata[15:8] == 8'h00));

    // R6
    bus_stat_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(acc.rd && acc.sel == SEL_BUSREQ))
            |-> (rdata == {{(DW-1){1'b0}}, !$past(cop_grant)}));

    // R11
    none_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(acc.rd && acc.sel == SEL_NONE)) |-> (rdata == '0));
endmodule

// File: tb/iolock_regfile_tb.sv
module iolock_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic        cop_grant = 1'b0;
    logic [23:0] port_din = {8'h7C, 8'h6B, 8'h5A};
    logic [15:0] rdata;
    logic [2:0]  port_rd, port_wr, port_ctl_wr;
    logic [7:0]  port_wdat;
    logic [23:0] port_ctl;
    logic        bus_req, cop_run, rom_en;
    logic [1:0]  vid_en;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    iolock_regfile dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
        .strap_export(1'b1), .strap_50hz(1'b0), .strap_no_exp(1'b1), .hw_ver(4'h1),
        .cop_grant(cop_grant), .port_din(port_din), .rdata(rdata),
        .port_rd(port_rd), .port_wr(port_wr), .port_ctl_wr(port_ctl_wr),
        .port_wdat(port_wdat), .port_ctl(port_ctl), .bus_req(bus_req),
        .cop_run(cop_run), .vid_en(vid_en), .rom_en(rom_en)
    );

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [23:0] a;
        logic [15:0] d;
        logic [15:0] e;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 24'hA10000, 16'h0000, 16'h00A1, 8'd2},
        '{1'b0, 1'b1, 24'hA10001, 16'h0000, 16'h00A1, 8'd10},
        '{1'b0, 1'b1, 24'hA10002, 16'h0000, 16'h005A, 8'd3},
        '{1'b0, 1'b1, 24'hA10005, 16'h0000, 16'h006B, 8'd3},
        '{1'b0, 1'b1, 24'hA10006, 16'h0000, 16'h007C, 8'd3},
        '{1'b1, 1'b0, 24'hA10008, 16'h1240, 16'h0000, 8'd5},
        '{1'b0, 1'b1, 24'hA10008, 16'h0000, 16'h0040, 8'd5},
        '{1'b1, 1'b0, 24'hA1000B, 16'hFF33, 16'h0000, 8'd5},
        '{1'b0, 1'b1, 24'hA1000A, 16'h0000, 16'h0033, 8'd5},
        '{1'b0, 1'b1, 24'hA1000C, 16'h0000, 16'h0000, 8'd5},
        '{1'b0, 1'b1, 24'hA11100, 16'h0000, 16'h0001, 8'd6},
        '{1'b0, 1'b1, 24'hA10010, 16'h0000, 16'h0000, 8'd11},
        '{1'b1, 1'b0, 24'hA10020, 16'hFFFF, 16'h0000, 8'd11},
        '{1'b0, 1'b1, 24'hA10008, 16'h0000, 16'h0040, 8'd11}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic op(input logic w, input logic r, input logic [23:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        @(posedge clk);
        #2;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check("R1 rom/vid/bus/cop", {28'd0, rom_en, vid_en, bus_req, cop_run}, 32'd0);
        check("R1 rdata/ctl", {rdata, 16'd0} | {8'd0, port_ctl}, 32'd0);
        @(negedge clk); rst = 1'b0;

        foreach (VECS[i]) begin
            op(VECS[i].wr, VECS[i].rd, VECS[i].a, VECS[i].d);
            if (VECS[i].rd)
                check($sformatf("R%0d vec %0d", VECS[i].req, i), {16'd0, rdata}, {16'd0, VECS[i].e});
        end

        // R3 read pulse only on port 1, for one cycle
        op(1'b0, 1'b1, 24'hA10004, 16'h0);
        check("R3 port_rd pulse", {29'd0, port_rd}, 32'b010);
        idle();
        check("R3 port_rd drop", {29'd0, port_rd}, 32'd0);

        // R4 data write strobe and byte
        op(1'b1, 1'b0, 24'hA10006, 16'h12C9);
        check("R4 port_wr", {29'd0, port_wr}, 32'b100);
        check("R4 port_wdat", {24'd0, port_wdat}, 32'hC9);
        idle();
        check("R4 port_wr drop", {29'd0, port_wr}, 32'd0);

        // R6 bus request and inverted grant status
        op(1'b1, 1'b0, 24'hA11100, 16'h0001);
        check("R6 bus_req set", {31'd0, bus_req}, 32'd1);
        cop_grant = 1'b1;
        op(1'b0, 1'b1, 24'hA11101, 16'h0);
        check("R6 status granted", {16'd0, rdata}, 32'd0);
        op(1'b1, 1'b0, 24'hA11100, 16'h0002);
        check("R6 bus_req clear", {31'd0, bus_req}, 32'd0);

        // R7 coprocessor run
        op(1'b1, 1'b0, 24'hA11200, 16'h0001);
        check("R7 cop_run set", {31'd0, cop_run}, 32'd1);
        op(1'b1, 1'b0, 24'hA11200, 16'h0000);
        check("R7 cop_run clear", {31'd0, cop_run}, 32'd0);

        // R8 signatures
        op(1'b1, 1'b0, 24'hA14000, 16'h5345);
        check("R8 vid0 set", {30'd0, vid_en}, 32'b01);
        op(1'b1, 1'b0, 24'hA14003, 16'h4741);
        check("R8 R10 vid1 set", {30'd0, vid_en}, 32'b11);
        op(1'b1, 1'b0, 24'hA14000, 16'h5344);
        check("R8 vid0 near miss", {30'd0, vid_en}, 32'b10);
        op(1'b1, 1'b0, 24'hA14002, 16'hC741);
        check("R8 vid1 near miss", {30'd0, vid_en}, 32'b00);

        // R9 rom enable
        op(1'b1, 1'b0, 24'hA14101, 16'h0001);
        check("R9 R10 rom_en set", {31'd0, rom_en}, 32'd1);
        op(1'b1, 1'b0, 24'hA14102, 16'h0000);
        check("R11 unlisted write", {31'd0, rom_en}, 32'd1);
        op(1'b1, 1'b0, 24'hA14100, 16'hFFFE);
        check("R9 rom_en clear", {31'd0, rom_en}, 32'd0);

        // R12 same-cycle read and write
        op(1'b1, 1'b1, 24'hA1000A, 16'h0055);
        check("R12 old value read", {16'd0, rdata}, 32'h33);
        check("R12 ctl updated", {24'd0, port_ctl[15:8]}, 32'h55);
        op(1'b0, 1'b1, 24'hA1000A, 16'h0);
        check("R12 new value read", {16'd0, rdata}, 32'h55);
        cop_grant = 1'b0;
        op(1'b1, 1'b1, 24'hA11100, 16'h0001);
        check("R12 status ignores request", {16'd0, rdata}, 32'd1);

        // R1 reset clears set state
        op(1'b1, 1'b0, 24'hA14100, 16'h0001);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #2;
        check("R1 second reset", {20'd0, rom_en, vid_en, bus_req, cop_run, port_ctl[15:8]}, 32'd0);
        @(negedge clk); rst = 1'b0;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule